// File: doc/BRIEF.md
# Reset Source Status Controller

This block keeps a record of why the system last went through reset. It offers that record as an 8-bit status value, and reading the value clears it. Six reset requests come in as synchronous pulses: a power-on request and five internal ones (watchdog, illegal opcode, illegal address, USB bus reset, low voltage). The block also watches an open-drain external reset line. It senses the line level on `pinIn` and pulls the line down through `pinDriveLow`.

Any internal cause, including power-on, starts the same sequence:

- The block pulls the external line low for a fixed pulse.
- It releases the line and waits a fixed number of clock cycles.
- It then samples the line. If something outside is still holding it low, the external-pin flag is set as well as the internal cause.

The system reset output `sysRstN` stays low from the start of the pulse until that sample has been taken. It stays low longer if the line is still held. A reset driven only from outside, with the block idle, holds the system in reset while the line is low. It sets the pin flag when the line is released. Flags accumulate until software reads them, so the value names a single cause only if it was cleared before the reset.

Top module: `rst_cause_ctrl`

## Requirements
- R1: The status value has this layout: bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 2 USB reset, bit 1 low voltage, bit 0 always 0.
- R2: A read strobe for one cycle clears every flag that `rdData` showed during that cycle.
- R3: A power-on request sets the value to 0x80 on the next edge, and this overrides every other flag and request.
- R4: Any other cause sets its own flag and keeps the flags already set.
- R5: After a power-on or internal request, `pinDriveLow` is high for exactly 64 cycles, starting on the next edge. A new internal request during the sequence restarts it.
- R6: After the line is released, the block samples `pinIn` on the 32nd rising edge. If the line is low there, bit 6 is set on that edge.
- R7: `sysRstN` is low from the pulse start until the sample edge. If the line was low at the sample, it stays low until the line goes high.
- R8: When a read and a new flag fall in the same cycle, the new flag survives and the flags that were read are cleared.
- R9: With the block idle and no internal cause, a low external line holds `sysRstN` low. Bit 6 is set on the edge where the line is seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| porReq | input | 1 | Power-on request, active high, also resets the block |
| wdogReq | input | 1 | Watchdog reset request |
| badOpReq | input | 1 | Illegal opcode reset request |
| badAddrReq | input | 1 | Illegal address reset request |
| usbRstReq | input | 1 | USB bus reset request |
| lowVoltReq | input | 1 | Low-voltage reset request |
| pinIn | input | 1 | Sensed level of the external reset line |
| pinDriveLow | output | 1 | High to pull the external line low |
| rdStrobe | input | 1 | One-cycle read strobe, clears the returned flags |
| rdData | output | 8 | Current status value |
| sysRstN | output | 1 | System reset, active low |

## Verification
The bench holds the external line low across the sample point after a low-voltage request. A design that samples at the wrong cycle, or that clears the internal flag, shows a value other than 0x42. It asserts a read together with a new illegal-address request. A design that lets the read win loses bit 3, and one that ignores the read keeps the old bits. It also runs power-on after other flags are set, two requests back to back without a read, and a reset driven purely from outside. A model in the bench compares `rdData`, `pinDriveLow` and `sysRstN` every cycle, so an off-by-one pulse or wait length shows up at the edge where it happens.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DRIVE   = 2'd1,
    ST_RELEASE = 2'd2,
    ST_HOLD    = 2'd3
  } rstPhase_t;

  typedef struct packed {
    logic setPin;
  } ctlStrobes_t;
endpackage

// File: rtl/rst_cause_ctrl_fsm.sv
module rst_cause_ctrl_fsm
  import rst_cause_pkg::*;
#(
  parameter int DRIVE_CYCLES = 64,
  parameter int SAMPLE_DELAY = 32
) (
  input  logic        clk,
  input  logic        porReq,
  input  logic        anyIntReq,
  input  logic        pinIn,
  output ctlStrobes_t strb,
  output logic        pinDriveLow,
  output logic        sysRstN
);
  localparam int MAX_CNT = (DRIVE_CYCLES > SAMPLE_DELAY) ? DRIVE_CYCLES : SAMPLE_DELAY;
  localparam int CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;
  localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_DELAY - 1);

  rstPhase_t phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    phaseNext   = phase;
    cntNext     = cnt;
    strb.setPin = 1'b0;
    if (porReq || anyIntReq) begin
      phaseNext = ST_DRIVE;
      cntNext   = '0;
    end else begin
      unique case (phase)
        ST_IDLE: if (!pinIn) phaseNext = ST_HOLD;
        ST_HOLD: if (pinIn) begin
          strb.setPin = 1'b1;
          phaseNext   = ST_IDLE;
        end
        ST_DRIVE: begin
          if (cnt == DRIVE_LAST) begin
            phaseNext = ST_RELEASE;
            cntNext   = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_RELEASE: begin
          if (cnt == SAMPLE_LAST) begin
            cntNext = '0;
            if (!pinIn) begin
              strb.setPin = 1'b1;
              phaseNext   = ST_HOLD;
            end else begin
              phaseNext = ST_IDLE;
            end
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        default: phaseNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    phase <= phaseNext;
    cnt   <= cntNext;
  end

  assign pinDriveLow = (phase == ST_DRIVE);
  assign sysRstN     = (phase == ST_IDLE);
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
  import rst_cause_pkg::*;
#(
  parameter int NUM_INT_SRC = 5
) (
  input  logic                   clk,
  input  logic                   porReq,
  input  logic                   rdStrobe,
  input  logic [NUM_INT_SRC-1:0] srcReq,
  input  ctlStrobes_t            strb,
  output logic [NUM_INT_SRC+2:0] flags
);
  localparam int REG_W   = NUM_INT_SRC + 3;
  localparam int POR_BIT = REG_W - 1;
  localparam int PIN_BIT = REG_W - 2;

  logic [REG_W-1:0] setMask;
  logic [REG_W-1:0] flagsReg;

  assign setMask[0]       = 1'b0;
  assign setMask[PIN_BIT] = strb.setPin;
  assign setMask[POR_BIT] = 1'b0;
  for (genvar i = 0; i < NUM_INT_SRC; i++) begin : g_src
    assign setMask[i+1] = srcReq[i];
  end

  always_ff @(posedge clk) begin
    if (porReq) begin
      flagsReg <= REG_W'(1) << POR_BIT;
    end else begin
      flagsReg <= (rdStrobe ? '0 : flagsReg) | setMask;
    end
  end

  assign flags = flagsReg;
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int DRIVE_CYCLES = 64,
  parameter int SAMPLE_DELAY = 32
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       wdogReq,
  input  logic       badOpReq,
  input  logic       badAddrReq,
  input  logic       usbRstReq,
  input  logic       lowVoltReq,
  input  logic       pinIn,
  output logic       pinDriveLow,
  input  logic       rdStrobe,
  output logic [7:0] rdData,
  output logic       sysRstN
);
  localparam int NUM_INT_SRC = 5;

  logic [NUM_INT_SRC-1:0] srcReq;
  ctlStrobes_t            strb;

  assign srcReq = {wdogReq, badOpReq, badAddrReq, usbRstReq, lowVoltReq};

  rst_cause_ctrl_fsm #(
    .DRIVE_CYCLES(DRIVE_CYCLES),
    .SAMPLE_DELAY(SAMPLE_DELAY)
  ) u_fsm (
    .clk        (clk),
    .porReq     (porReq),
    .anyIntReq  (|srcReq),
    .pinIn      (pinIn),
    .strb       (strb),
    .pinDriveLow(pinDriveLow),
    .sysRstN    (sysRstN)
  );

  rst_cause_flags #(
    .NUM_INT_SRC(NUM_INT_SRC)
  ) u_flags (
    .clk     (clk),
    .porReq  (porReq),
    .rdStrobe(rdStrobe),
    .srcReq  (srcReq),
    .strb    (strb),
    .flags   (rdData)
  );
endmodule

// File: rtl/rst_cause_checks.sv
module rst_cause_checks (
  input logic       clk,
  input logic       porReq,
  input logic       wdogReq,
  input logic       badOpReq,
  input logic       badAddrReq,
  input logic       usbRstReq,
  input logic       lowVoltReq,
  input logic       rdStrobe,
  input logic [7:0] rdData,
  input logic       pinDriveLow,
  input logic       sysRstN
);
  logic anyInt;
  assign anyInt = wdogReq | badOpReq | badAddrReq | usbRstReq | lowVoltReq;

  // R3: power-on leaves exactly the power-on flag
  p_por_value_r3: assert property (@(posedge clk) disable iff (1'b0)
    porReq |=> (rdData == 8'h80));

  // R1: bit 0 never set
  p_bit0_zero_r1: assert property (@(posedge clk) disable iff (porReq)
    rdData[0] == 1'b0);

  // R4: without a read no flag is lost
  p_sticky_r4: assert property (@(posedge clk) disable iff (porReq)
    !rdStrobe |=> ((rdData & $past(rdData)) == $past(rdData)));

  // R2: read with no new internal request clears the cause bits
  p_read_clear_r2: assert property (@(posedge clk) disable iff (porReq)
    (rdStrobe && !anyInt) |=> (rdData[7] == 1'b0 && rdData[5:0] == 6'd0));

  // R7: system stays in reset while the line is driven
  p_drive_in_reset_r7: assert property (@(posedge clk) disable iff (porReq)
    pinDriveLow |-> !sysRstN);

  // R5: end of pulse is followed by the wait, still in reset
  p_release_in_reset_r5: assert property (@(posedge clk) disable iff (porReq)
    $fell(pinDriveLow) |-> !sysRstN);

  // R5: an internal request starts the drive on the next edge
  p_req_drives_r5: assert property (@(posedge clk) disable iff (porReq)
    anyInt |=> pinDriveLow);
endmodule

bind rst_cause_ctrl rst_cause_checks u_checks (
  .clk        (clk),
  .porReq     (porReq),
  .wdogReq    (wdogReq),
  .badOpReq   (badOpReq),
  .badAddrReq (badAddrReq),
  .usbRstReq  (usbRstReq),
  .lowVoltReq (lowVoltReq),
  .rdStrobe   (rdStrobe),
  .rdData     (rdData),
  .pinDriveLow(pinDriveLow),
  .sysRstN    (sysRstN)
);

// File: tb/sim_rst_cause_ctrl.sv
module sim_rst_cause_ctrl;
  logic clk = 1'b0;
  logic porReq = 1'b1;
  logic wdogReq = 0, badOpReq = 0, badAddrReq = 0, usbRstReq = 0, lowVoltReq = 0;
  logic rdStrobe = 0;
  logic extHold = 0;
  logic pinIn, pinDriveLow, sysRstN;
  logic [7:0] rdData;
  int checks = 0, errors = 0;
  bit started = 0, done = 0;

  always #5 clk = ~clk;

  assign pinIn = !(pinDriveLow || extHold);

  rst_cause_ctrl u0 (
    .clk(clk), .porReq(porReq), .wdogReq(wdogReq), .badOpReq(badOpReq),
    .badAddrReq(badAddrReq), .usbRstReq(usbRstReq), .lowVoltReq(lowVoltReq),
    .pinIn(pinIn), .pinDriveLow(pinDriveLow), .rdStrobe(rdStrobe),
    .rdData(rdData), .sysRstN(sysRstN)
  );

  // behavioural reference: phase 0 idle, 1 driving, 2 waiting, 3 held outside
  int mPhase = 0, mCount = 0;
  logic [7:0] mFlags = 8'h80;

  always @(posedge clk) begin
    logic [7:0] setM;
    bit lineHigh, anyInt;
    lineHigh = !(mPhase == 1) && !extHold;
    anyInt = wdogReq | badOpReq | badAddrReq | usbRstReq | lowVoltReq;
    setM = {1'b0, 1'b0, wdogReq, badOpReq, badAddrReq, usbRstReq, lowVoltReq, 1'b0};
    if (porReq) begin
      mFlags = 8'h80; mPhase = 1; mCount = 0;
    end else begin
      if (anyInt) begin
        mPhase = 1; mCount = 0;
      end else if (mPhase == 0) begin
        if (!lineHigh) mPhase = 3;
      end else if (mPhase == 3) begin
        if (lineHigh) begin setM[6] = 1'b1; mPhase = 0; end
      end else if (mPhase == 1) begin
        mCount++;
        if (mCount == 64) begin mPhase = 2; mCount = 0; end
      end else begin
        mCount++;
        if (mCount == 32) begin
          mCount = 0;
          if (!lineHigh) begin setM[6] = 1'b1; mPhase = 3; end
          else mPhase = 0;
        end
      end
      mFlags = (rdStrobe ? 8'h00 : mFlags) | setM;
    end
    started = 1;
  end

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model (outputs are all registered)
  always @(negedge clk) if (started && !done) begin
    check("R1", "rdData", rdData, mFlags);
    check("R5", "pinDriveLow", {7'd0, pinDriveLow}, {7'd0, mPhase == 1});
    check("R7", "sysRstN", {7'd0, sysRstN}, {7'd0, mPhase == 0});
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readReg();
    @(negedge clk) rdStrobe = 1;
    @(negedge clk) rdStrobe = 0;
  endtask

  initial begin
    cycles(3);
    porReq = 0;
    check("R3", "por value", rdData, 8'h80);
    check("R7", "in reset after por", {7'd0, sysRstN}, 8'd0);
    cycles(110);
    check("R3", "por after sequence", rdData, 8'h80);
    check("R7", "released", {7'd0, sysRstN}, 8'd1);
    readReg();
    check("R2", "cleared by read", rdData, 8'h00);
    // watchdog then illegal opcode, no read between
    @(negedge clk) wdogReq = 1;
    @(negedge clk) begin wdogReq = 0; end
    check("R5", "drive starts", {7'd0, pinDriveLow}, 8'd1);
    cycles(110);
    check("R4", "watchdog flag", rdData, 8'h20);
    @(negedge clk) badOpReq = 1;
    @(negedge clk) badOpReq = 0;
    cycles(110);
    check("R4", "accumulated", rdData, 8'h30);
    // read and a new cause in the same cycle
    @(negedge clk) begin rdStrobe = 1; badAddrReq = 1; end
    @(negedge clk) begin rdStrobe = 0; badAddrReq = 0; end
    check("R8", "read vs set", rdData, 8'h08);
    cycles(110);
    readReg();
    // low voltage with the line held from outside across the sample
    @(negedge clk) begin lowVoltReq = 1; extHold = 1; end
    @(negedge clk) lowVoltReq = 0;
    cycles(110);
    check("R6", "held at sample", rdData, 8'h42);
    check("R7", "still held", {7'd0, sysRstN}, 8'd0);
    extHold = 0;
    cycles(4);
    check("R7", "release after hold", {7'd0, sysRstN}, 8'd1);
    readReg();
    check("R2", "cleared", rdData, 8'h00);
    // external reset alone
    extHold = 1;
    cycles(10);
    check("R9", "held outside", {7'd0, sysRstN}, 8'd0);
    check("R9", "no flag yet", rdData, 8'h00);
    extHold = 0;
    cycles(3);
    check("R9", "pin flag only", rdData, 8'h40);
    // USB reset then power-on wipes it
    @(negedge clk) usbRstReq = 1;
    @(negedge clk) usbRstReq = 0;
    cycles(20);
    check("R4", "usb kept with pin", rdData, 8'h44);
    @(negedge clk) porReq = 1;
    @(negedge clk) porReq = 0;
    check("R3", "por wipes", rdData, 8'h80);
    cycles(110);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule